// File: doc/BRIEF.md
# USB IN Endpoint Handshake Controller

This block holds the control and status register of one bulk-style USB device IN endpoint. It also decides which handshake the link layer returns for each IN token. The core reads and writes the register through a simple byte-wide port and loads packet data one byte per strobe. The link layer reports IN tokens, packet completion, FIFO underruns, host protocol violations, and decoded SET_CONFIGURATION, SET_INTERFACE and CLEAR_FEATURE requests.

Data flows through two 64-byte transmit buffers that are used in ping-pong order. The block tracks each buffer's fill count and whether it has been triggered for sending. A buffer is triggered when it holds a full packet, or earlier when the core marks a short packet. When a flush is requested, the block empties both buffers and pulses a flush output to the FIFO storage. A packet-complete status drives an interrupt request unless it is masked, so DMA-fed transfers can run without the core.

Stalls can be forced by the core. When a forced STALL actually goes out on the bus, a sent-stall status is set and the force request clears itself in the same update. A STALL caused by a host protocol violation does not set the sent-stall status.

Top module: `usb_in_endpoint`

## Requirements
- R1: After reset the register reads 0x00, no handshake is reported (hsValid low) and txIrq is low.
- R2: A buffer is triggered when its 64th byte is loaded. An IN token that finds the next buffer in ping-pong order triggered, with no stall and no packet in flight, is answered DATA (hsCode 0) one cycle later, and that packet is then in flight until txDone or underrun.
- R3: Writing 1 to register bit 7 (short packet) triggers the current write buffer with whatever it holds, including zero bytes, and bit 7 reads 1. It is ignored when that buffer is already triggered. Bit 7 clears when the short packet completes with txDone.
- R4: An IN token is answered NAK (hsCode 1) when no buffer is triggered or while a packet is in flight, unless a stall is in effect.
- R5: Writing 1 to bit 2, or a setConfig or setIntf strobe, empties both buffers, restarts the ping-pong order, ends any packet in flight and clears bit 7. fifoFlush pulses high for one cycle on the next cycle. Bit 2 always reads 0.
- R6: An underrun strobe sets bit 3. If a packet is in flight it is ended with its buffer kept for a retry. Bit 3 never drives txIrq. Writing 1 to bit 3 clears it.
- R7: While bit 5 (force stall) is set, IN tokens are answered STALL (hsCode 2), except while a packet is in flight, when they are answered NAK.
- R8: When a STALL goes out because of bit 5, bit 4 (sent stall) sets and bit 5 clears in the same update. The endpoint then keeps answering STALL. Writing 1 to bit 4 clears it.
- R9: A protoErr strobe makes the endpoint answer STALL to IN tokens without setting bit 4.
- R10: A clearFeature strobe ends any stall and clears bit 5. Normal DATA/NAK answers resume even while bit 4 is still set.
- R11: txDone while a packet is in flight frees its buffer and sets bit 0, which is cleared by writing 1. txIrq is bit 0 AND NOT bit 1 (mask, plain read/write).
- R12: Bit 6 always reads 0, and writing it changes nothing.
- R13: Bytes loaded while the current write buffer is triggered (both buffers full) are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read value |
| byteWr | input | 1 | Load one data byte into the current write buffer |
| inToken | input | 1 | IN token received |
| protoErr | input | 1 | Host protocol violation, automatic stall |
| txDone | input | 1 | Packet sent and acknowledged |
| underrun | input | 1 | Transmit FIFO underrun |
| setConfig | input | 1 | SET_CONFIGURATION request decoded |
| setIntf | input | 1 | SET_INTERFACE request decoded |
| clearFeature | input | 1 | CLEAR_FEATURE request decoded |
| hsValid | output | 1 | Handshake decision valid |
| hsCode | output | 2 | Handshake: 0 DATA, 1 NAK, 2 STALL |
| fifoFlush | output | 1 | Flush pulse to transmit FIFO storage |
| txIrq | output | 1 | Packet-complete interrupt request |

## Verification
Every result is registered once. A handshake for a token seen at one edge is valid on the cycle after it. Register bits, txIrq and fifoFlush reflect a strobe or write one cycle after it is presented. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which is one full register stage later. A behavioural model advances on the same rising edge as the design and is compared on every cycle. Directed checks at the points where each requirement's effect is due add an absolute expected value on top of that.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    HS_DATA  = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hsCode_e;

  localparam int BIT_TPC   = 0;
  localparam int BIT_MASK  = 1;
  localparam int BIT_FLUSH = 2;
  localparam int BIT_TUR   = 3;
  localparam int BIT_SST   = 4;
  localparam int BIT_FST   = 5;
  localparam int BIT_RSV   = 6;
  localparam int BIT_TSP   = 7;

  typedef struct packed {
    logic flush;
    logic loadByte;
    logic shortTrig;
    logic sendDone;
  } bufCmd_t;
endpackage

// File: rtl/usb_in_ep_bufs.sv
module usb_in_ep_bufs
  import usb_in_ep_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int NUM_BUF = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  bufCmd_t cmd,
  output logic    rdReady,
  output logic    rdShort,
  output logic    wrTriggered
);
  localparam int CNT_W = $clog2(MAX_PKT + 1);
  localparam int SEL_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_PKT - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_PKT);

  logic [CNT_W-1:0] fillCnt [NUM_BUF];
  logic [NUM_BUF-1:0] trig;
  logic [SEL_W-1:0] wrSel, rdSel;
  logic wrClose;

  function automatic logic [SEL_W-1:0] nextSel(input logic [SEL_W-1:0] s);
    return (s == SEL_W'(NUM_BUF - 1)) ? '0 : s + 1'b1;
  endfunction

  assign wrTriggered = trig[wrSel];
  assign rdReady     = trig[rdSel];
  assign rdShort     = fillCnt[rdSel] != FULL_CNT;
  assign wrClose     = !wrTriggered &&
                       ((cmd.loadByte && fillCnt[wrSel] == LAST_IDX) ||
                        (!cmd.loadByte && cmd.shortTrig));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSel <= '0;
      rdSel <= '0;
    end else if (cmd.flush) begin
      wrSel <= '0;
      rdSel <= '0;
    end else begin
      if (wrClose) wrSel <= nextSel(wrSel);
      if (cmd.sendDone) rdSel <= nextSel(rdSel);
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : gBuf
    logic isWr, isRd;
    assign isWr = wrSel == SEL_W'(g);
    assign isRd = rdSel == SEL_W'(g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fillCnt[g] <= '0;
        trig[g]    <= 1'b0;
      end else if (cmd.flush) begin
        fillCnt[g] <= '0;
        trig[g]    <= 1'b0;
      end else if (cmd.sendDone && isRd) begin
        fillCnt[g] <= '0;
        trig[g]    <= 1'b0;
      end else if (isWr && !trig[g]) begin
        if (cmd.loadByte) begin
          fillCnt[g] <= fillCnt[g] + 1'b1;
          if (fillCnt[g] == LAST_IDX) trig[g] <= 1'b1;
        end else if (cmd.shortTrig) begin
          trig[g] <= 1'b1;
        end
      end
    end

    // R2: a buffer never holds more than one packet
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
      fillCnt[g] <= FULL_CNT);
    // R2: a full buffer is always triggered
    p_full_trig_r2: assert property (@(posedge clk) disable iff (!rstN)
      (fillCnt[g] == FULL_CNT) |-> trig[g]);
    // R13: loads into a triggered buffer leave its count unchanged
    p_drop_r13: assert property (@(posedge clk) disable iff (!rstN)
      (trig[g] && isWr && cmd.loadByte && !cmd.flush && !(cmd.sendDone && isRd))
        |=> $stable(fillCnt[g]));
  end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       byteWr,
  input  logic       inToken,
  input  logic       protoErr,
  input  logic       txDone,
  input  logic       underrun,
  input  logic       setConfig,
  input  logic       setIntf,
  input  logic       clearFeature,
  input  logic       rdReady,
  input  logic       rdShort,
  input  logic       wrTriggered,
  output bufCmd_t    cmd,
  output logic [7:0] regRdData,
  output logic       hsValid,
  output logic [1:0] hsCode,
  output logic       fifoFlush,
  output logic       txIrq
);
  logic tpc, mask, tur, sst, fst, tsp, stallActive, busy;
  logic flushReq, stallOut, forcedSend, dataSend, doneEvt, urEvt, tspAccept;
  hsCode_e hsNext;

  function automatic logic wrOne(input int b);
    return regWrEn && regWrData[b];
  endfunction

  assign flushReq   = wrOne(BIT_FLUSH) || setConfig || setIntf;
  assign stallOut   = stallActive || (fst && !busy);
  assign forcedSend = inToken && fst && !busy;
  assign dataSend   = inToken && !stallOut && !busy && rdReady;
  assign doneEvt    = txDone && busy;
  assign urEvt      = underrun && busy;
  assign tspAccept  = wrOne(BIT_TSP) && !wrTriggered && !byteWr;

  always_comb begin
    cmd.flush     = flushReq;
    cmd.loadByte  = byteWr;
    cmd.shortTrig = tspAccept;
    cmd.sendDone  = doneEvt && !flushReq;
  end

  always_comb begin
    if (stallOut)              hsNext = HS_STALL;
    else if (!busy && rdReady) hsNext = HS_DATA;
    else                       hsNext = HS_NAK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      stallActive <= 1'b0;
      fst         <= 1'b0;
      sst         <= 1'b0;
      tur         <= 1'b0;
      tpc         <= 1'b0;
      mask        <= 1'b0;
      tsp         <= 1'b0;
      hsValid     <= 1'b0;
      hsCode      <= HS_NAK;
      fifoFlush   <= 1'b0;
    end else begin
      hsValid   <= inToken;
      hsCode    <= hsNext;
      fifoFlush <= flushReq;

      if (flushReq)                busy <= 1'b0;
      else if (dataSend)           busy <= 1'b1;
      else if (doneEvt || urEvt)   busy <= 1'b0;

      if (clearFeature)                  stallActive <= 1'b0;
      else if (forcedSend || protoErr)   stallActive <= 1'b1;

      if (clearFeature || forcedSend)    fst <= 1'b0;
      else if (wrOne(BIT_FST))           fst <= 1'b1;

      if (forcedSend)                    sst <= 1'b1;
      else if (wrOne(BIT_SST))           sst <= 1'b0;

      if (underrun)                      tur <= 1'b1;
      else if (wrOne(BIT_TUR))           tur <= 1'b0;

      if (doneEvt)                       tpc <= 1'b1;
      else if (wrOne(BIT_TPC))           tpc <= 1'b0;

      if (regWrEn)                       mask <= regWrData[BIT_MASK];

      if (flushReq)                      tsp <= 1'b0;
      else if (doneEvt && rdShort)       tsp <= 1'b0;
      else if (tspAccept)                tsp <= 1'b1;
    end
  end

  always_comb begin
    regRdData           = '0;
    regRdData[BIT_TPC]  = tpc;
    regRdData[BIT_MASK] = mask;
    regRdData[BIT_TUR]  = tur;
    regRdData[BIT_SST]  = sst;
    regRdData[BIT_FST]  = fst;
    regRdData[BIT_TSP]  = tsp;
  end

  assign txIrq = tpc && !mask;

  // R8: sent-stall only rises after a forced request was pending
  p_sst_needs_fst_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sst) |-> $past(fst));
  // R8: a forced stall going out clears the request and reports it
  p_fst_selfclear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inToken && fst && !busy && !clearFeature)
      |=> (!fst && sst && hsValid && hsCode == HS_STALL));
  // R4: a token during a packet in flight without stall gets NAK
  p_busy_nak_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inToken && busy && !stallActive) |=> (hsValid && hsCode == HS_NAK));
  // R5: configuration requests flush the FIFO one cycle later
  p_cfg_flush_r5: assert property (@(posedge clk) disable iff (!rstN)
    (setConfig || setIntf) |=> fifoFlush);
  // R9: an automatic stall alone never raises sent-stall
  p_proto_nosst_r9: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !inToken && !sst) |=> !sst);
  // R12: writes to the reserved bit never show up
  p_rsv_ignored_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[BIT_RSV]) |=> !regRdData[BIT_RSV]);
endmodule

// File: rtl/usb_in_endpoint.sv
module usb_in_endpoint
  import usb_in_ep_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int NUM_BUF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       byteWr,
  input  logic       inToken,
  input  logic       protoErr,
  input  logic       txDone,
  input  logic       underrun,
  input  logic       setConfig,
  input  logic       setIntf,
  input  logic       clearFeature,
  output logic       hsValid,
  output logic [1:0] hsCode,
  output logic       fifoFlush,
  output logic       txIrq
);
  bufCmd_t cmd;
  logic rdReady, rdShort, wrTriggered;

  usb_in_ep_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .byteWr(byteWr), .inToken(inToken), .protoErr(protoErr),
    .txDone(txDone), .underrun(underrun),
    .setConfig(setConfig), .setIntf(setIntf), .clearFeature(clearFeature),
    .rdReady(rdReady), .rdShort(rdShort), .wrTriggered(wrTriggered),
    .cmd(cmd), .regRdData(regRdData),
    .hsValid(hsValid), .hsCode(hsCode),
    .fifoFlush(fifoFlush), .txIrq(txIrq)
  );

  usb_in_ep_bufs #(.MAX_PKT(MAX_PKT), .NUM_BUF(NUM_BUF)) uBufs (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rdReady(rdReady), .rdShort(rdShort), .wrTriggered(wrTriggered)
  );
endmodule

// File: tb/usb_in_endpoint_test.sv
module usb_in_endpoint_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, byteWr = 0, inToken = 0, protoErr = 0, txDone = 0;
  logic underrun = 0, setConfig = 0, setIntf = 0, clearFeature = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic hsValid, fifoFlush, txIrq;
  logic [1:0] hsCode;

  int total = 0;
  int failed = 0;

  usb_in_endpoint uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .byteWr(byteWr), .inToken(inToken),
    .protoErr(protoErr), .txDone(txDone), .underrun(underrun),
    .setConfig(setConfig), .setIntf(setIntf), .clearFeature(clearFeature),
    .hsValid(hsValid), .hsCode(hsCode), .fifoFlush(fifoFlush), .txIrq(txIrq)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int mCnt[2];
  bit mTrig[2];
  int mWr, mRd;
  bit mBusy, mStall, mFst, mSst, mTur, mTpc, mMask, mTsp, mHsV, mFlush;
  int mHs;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt[0] = 0; mCnt[1] = 0; mTrig[0] = 0; mTrig[1] = 0;
      mWr = 0; mRd = 0; mBusy = 0; mStall = 0; mFst = 0; mSst = 0;
      mTur = 0; mTpc = 0; mMask = 0; mTsp = 0; mHsV = 0; mHs = 1; mFlush = 0;
    end else begin
      bit flushNow, stallNow, forced, done, shortSent, tspOk;
      flushNow = (regWrEn && regWrData[2]) || setConfig || setIntf;
      stallNow = mStall || (mFst && !mBusy);
      forced = inToken && mFst && !mBusy;
      done = txDone && mBusy;
      shortSent = mCnt[mRd] != 64;
      tspOk = regWrEn && regWrData[7] && !mTrig[mWr] && !byteWr;
      mHsV = inToken;
      mHs = stallNow ? 2 : ((!mBusy && mTrig[mRd]) ? 0 : 1);
      mFlush = flushNow;
      if (flushNow) begin
        mCnt[0] = 0; mCnt[1] = 0; mTrig[0] = 0; mTrig[1] = 0; mWr = 0; mRd = 0;
      end else begin
        if (!mTrig[mWr] && byteWr) begin
          mCnt[mWr]++;
          if (mCnt[mWr] == 64) begin mTrig[mWr] = 1; mWr ^= 1; end
        end else if (tspOk) begin
          mTrig[mWr] = 1; mWr ^= 1;
        end
        if (done) begin mCnt[mRd] = 0; mTrig[mRd] = 0; mRd ^= 1; end
      end
      if (flushNow || tspOk && 0) mTsp = 0;
      if (flushNow) mTsp = 0;
      else if (done && shortSent) mTsp = 0;
      else if (tspOk) mTsp = 1;
      if (flushNow) mBusy = 0;
      else if (inToken && !stallNow && !mBusy && mHs == 0) mBusy = 1;
      else if (done || (underrun && mBusy)) mBusy = 0;
      if (clearFeature) mStall = 0; else if (forced || protoErr) mStall = 1;
      if (clearFeature || forced) mFst = 0; else if (regWrEn && regWrData[5]) mFst = 1;
      if (forced) mSst = 1; else if (regWrEn && regWrData[4]) mSst = 0;
      if (underrun) mTur = 1; else if (regWrEn && regWrData[3]) mTur = 0;
      if (done) mTpc = 1; else if (regWrEn && regWrData[0]) mTpc = 0;
      if (regWrEn) mMask = regWrData[1];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int expRd;
      expRd = mTpc | (mMask << 1) | (mTur << 3) | (mSst << 4) | (mFst << 5) | (mTsp << 7);
      chk("R2 R4 R7 handshake valid", hsValid, mHsV);
      if (mHsV) chk("R2 R4 R7 R9 handshake code", hsCode, mHs);
      chk("R5 flush pulse", fifoFlush, mFlush);
      chk("R3 R6 R8 R11 register read", regRdData, expRd);
      chk("R11 interrupt", txIrq, mTpc && !mMask);
    end
  end

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1; regWrData = v;
    @(negedge clk); regWrEn = 0; regWrData = '0;
  endtask

  task automatic pushBytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byteWr = 1;
    end
    @(negedge clk); byteWr = 0;
  endtask

  // 0 token, 1 txDone, 2 underrun, 3 protoErr, 4 setConfig, 5 setIntf, 6 clearFeature
  task automatic pulse(input int sel);
    @(negedge clk);
    case (sel)
      0: inToken = 1;
      1: txDone = 1;
      2: underrun = 1;
      3: protoErr = 1;
      4: setConfig = 1;
      5: setIntf = 1;
      default: clearFeature = 1;
    endcase
    @(negedge clk);
    inToken = 0; txDone = 0; underrun = 0; protoErr = 0;
    setConfig = 0; setIntf = 0; clearFeature = 0;
  endtask

  function automatic int hs();
    return hsValid * 4 + hsCode;
  endfunction

  localparam int HDATA = 4, HNAK = 5, HSTALL = 6;

  initial begin
    #(200000 * 10);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset read", regRdData, 0);
    chk("R1 reset handshake", hsValid, 0);
    chk("R1 reset irq", txIrq, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 idle read", regRdData, 0);

    // R4 empty endpoint
    pulse(0); chk("R4 nak when empty", hs(), HNAK);
    // R2 full packet
    pushBytes(64);
    pulse(0); chk("R2 data after 64 bytes", hs(), HDATA);
    pulse(0); chk("R4 nak while in flight", hs(), HNAK);
    pulse(1);
    chk("R11 complete status", regRdData[0], 1);
    chk("R11 irq raised", txIrq, 1);
    wrReg(8'h02); chk("R11 mask hides irq", txIrq, 0);
    wrReg(8'h03); chk("R11 w1c clears status", regRdData[0], 0);
    chk("R11 mask kept", regRdData[1], 1);
    wrReg(8'h00);

    // R3 zero-length packet
    wrReg(8'h80); chk("R3 short bit set", regRdData[7], 1);
    pulse(0); chk("R3 zero-length data", hs(), HDATA);
    pulse(1); chk("R3 short bit cleared on completion", regRdData[7], 0);
    wrReg(8'h01);

    // R13 ping-pong and dropped bytes
    pushBytes(64); pushBytes(64);
    wrReg(8'h80); chk("R3 short ignored when full", regRdData[7], 0);
    pushBytes(1);
    pulse(0); chk("R2 first of pair", hs(), HDATA);
    pulse(1);
    pushBytes(63);
    pulse(0); chk("R2 second of pair", hs(), HDATA);
    pulse(1);
    pulse(0); chk("R13 dropped byte not counted", hs(), HNAK);
    pushBytes(1);
    pulse(0); chk("R2 ping-pong wrap", hs(), HDATA);
    pulse(1);
    wrReg(8'h01);

    // R5 flush sources
    pushBytes(64); wrReg(8'h80);
    wrReg(8'h04);
    chk("R5 flush pulse from bit", fifoFlush, 1);
    chk("R5 flush bit reads zero", regRdData[2], 0);
    chk("R5 short bit cleared by flush", regRdData[7], 0);
    pulse(0); chk("R5 nak after flush", hs(), HNAK);
    pushBytes(64); pulse(4);
    chk("R5 flush pulse from setConfig", fifoFlush, 1);
    pulse(0); chk("R5 nak after setConfig", hs(), HNAK);
    pushBytes(64); pulse(5);
    chk("R5 flush pulse from setIntf", fifoFlush, 1);
    pulse(0); chk("R5 nak after setIntf", hs(), HNAK);

    // R6 underrun
    pushBytes(64);
    pulse(0); pulse(2);
    chk("R6 underrun status", regRdData[3], 1);
    chk("R6 no irq from underrun", txIrq, 0);
    pulse(0); chk("R6 buffer kept for retry", hs(), HDATA);
    pulse(1);
    wrReg(8'h09); chk("R6 underrun w1c", regRdData[3], 0);

    // R7 R8 R10 forced stall
    pushBytes(64);
    pulse(0);
    wrReg(8'h20); chk("R7 force bit set", regRdData[5], 1);
    pulse(0); chk("R7 nak while in flight", hs(), HNAK);
    chk("R8 no sent-stall yet", regRdData[4], 0);
    pulse(1);
    pulse(0); chk("R7 stall handshake", hs(), HSTALL);
    chk("R8 sent-stall set", regRdData[4], 1);
    chk("R8 force bit self-cleared", regRdData[5], 0);
    pushBytes(64);
    pulse(0); chk("R8 stall persists", hs(), HSTALL);
    pulse(6);
    pulse(0); chk("R10 normal after clear", hs(), HDATA);
    chk("R10 sent-stall still set", regRdData[4], 1);
    pulse(1);
    wrReg(8'h11); chk("R8 sent-stall w1c", regRdData[4], 0);
    wrReg(8'h20); pulse(6);
    chk("R10 clear drops force bit", regRdData[5], 0);
    pulse(0); chk("R10 no stall after clear", hs(), HNAK);

    // R9 protocol stall
    pulse(3);
    pulse(0); chk("R9 protocol stall", hs(), HSTALL);
    chk("R9 no sent-stall", regRdData[4], 0);
    pulse(6);
    pulse(0); chk("R9 stall ended", hs(), HNAK);

    // R12 reserved bit
    wrReg(8'h42);
    chk("R12 reserved reads zero", regRdData[6], 0);
    chk("R12 register otherwise as written", regRdData, 8'h02);
    wrReg(8'h00);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule